// File: doc/BRIEF.md
# Display Controller Command Port Decoder

This block sits behind the command port of a video display controller and turns each written word into either a register-write strobe or an update of the access address and the access code. Words arrive either whole, 16 bits wide, or as two consecutive bytes on an 8-bit compatibility bus. On the byte bus the bytes are paired into a word before decoding.

Two command protocols share the decoder. The mode input selects between them:

- **Extended protocol** (mode input high): a non-register word opens a two-word sequence. The following word is taken as its second half.
- **Compatibility protocol** (mode input low): every word completes at once. A non-register word signals the read prefetch logic to drop any fetched or half-fetched data.

The second half of an extended sequence is handled here by a plain latch that loads only the two top address bits. Transfer-engine control is left to other blocks.

A read of the command port clears every pending sequence state.

Top module: `ctrl_cmd_decoder`

## Requirements
- R1: After reset, `addr_o` = 0, `code_o` = 0, `cmd_pending_o` = 0, `byte_pending_o` = 0, `reg_we_o` = 0 and `clr_fetch_o` = 0.
- R2: A word decoded with no command pending loads `addr_o[13:0]` from word bits 13:0 and leaves `addr_o[15:14]` unchanged.
- R3: A word decoded with no command pending loads `code_o[1:0]` from word bits 15:14. `code_o[5:2]` is kept when `mode5_i`=1 and cleared to 0 when `mode5_i`=0.
- R4: A word whose bits 15:14 equal 2'b10 is a register write. `reg_idx_o` is word bits 12:8 and `reg_data_o` is word bits 7:0. `reg_we_o` pulses for one cycle, and address and code still update as in R2 and R3.
- R5: A register write is strobed only if its index is below NUM_REGS (24) when `mode5_i`=1, or below M4_REGS (11) when `mode5_i`=0. Otherwise `reg_we_o` stays 0.
- R6: With `mode5_i`=1, a non-register word decoded with no command pending sets `cmd_pending_o`. The next decoded word is a second word:
  - it sets `addr_o[15:14]` to its bits 1:0;
  - it keeps `addr_o[13:0]` and `code_o`;
  - it produces no register strobe;
  - it clears `cmd_pending_o`.
- R7: With `mode5_i`=0, a non-register word leaves `cmd_pending_o` at 0 and pulses `clr_fetch_o` for one cycle.
- R8: On the byte bus the first byte is held as the low half and sets `byte_pending_o`. The second byte is the high half: the joined word is decoded and `byte_pending_o` clears.
- R9: When a word from the byte bus leaves `code_o` at 6'b000000 (16-bit video RAM read), the code becomes 6'b001100 (8-bit video RAM read).
- R10: `rd_i` clears `cmd_pending_o` and `byte_pending_o`. Any write in the same cycle is ignored.
- R11: If `wr16_valid_i` and `wr8_valid_i` are both high, the 16-bit word is decoded and the byte is ignored, so `byte_pending_o` is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode5_i | input | 1 | 1: two-word protocol, 0: single-word protocol |
| wr16_valid_i | input | 1 | 16-bit command word write |
| wr16_data_i | input | 16 | 16-bit command word |
| wr8_valid_i | input | 1 | Byte-bus command write |
| wr8_data_i | input | 8 | Byte-bus data |
| rd_i | input | 1 | Command port read |
| reg_we_o | output | 1 | Register write strobe |
| reg_idx_o | output | 5 | Register index |
| reg_data_o | output | 8 | Register data |
| addr_o | output | 16 | Access address |
| code_o | output | 6 | Access code |
| cmd_pending_o | output | 1 | Second word expected |
| byte_pending_o | output | 1 | Low byte held |
| clr_fetch_o | output | 1 | Drop prefetch state pulse |

## Verification
Every result of this block is registered once. A write or read sampled at one rising edge therefore shows on the address, code, pending flags and the one-cycle strobes right after that edge, and is gone (for the strobes) one edge later. The driver changes inputs at falling edges and queues the expected snapshot for the coming rising edge. The monitor compares shortly after that rising edge, so each vector is checked in exactly the cycle its result is due. Byte pairs take two vectors: the first checks only the held-byte flag, and the second checks the decoded outcome.

// File: rtl/ccd_pkg.sv
package ccd_pkg;
  localparam int WORD_W = 16;
  localparam int BYTE_W = 8;
  localparam int CODE_W = 6;
  localparam int IDX_W  = 5;
  localparam int HI_ADDR_W = 2;
  localparam int LO_ADDR_W = WORD_W - HI_ADDR_W;

  localparam logic [CODE_W-1:0] CODE_VRAM_RD16 = 6'b000000;
  localparam logic [CODE_W-1:0] CODE_VRAM_RD8  = 6'b001100;
  localparam logic [1:0]        KIND_REG       = 2'b10;

  typedef struct packed {
    logic [WORD_W-1:0] addr;
    logic [CODE_W-1:0] code;
  } cmd_state_t;
endpackage

// File: rtl/ccd_byte_joiner.sv
module ccd_byte_joiner
  import ccd_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              byte_valid_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              clear_i,
  output logic              word_valid_o,
  output logic [WORD_W-1:0] word_o,
  output logic              pending_o
);
  logic              pend_q;
  logic [BYTE_W-1:0] hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      hold_q <= '0;
    end else if (clear_i) begin
      pend_q <= 1'b0;
    end else if (byte_valid_i) begin
      if (pend_q) begin
        pend_q <= 1'b0;
      end else begin
        pend_q <= 1'b1;
        hold_q <= byte_i;
      end
    end
  end

  assign word_valid_o = byte_valid_i & pend_q & ~clear_i;
  assign word_o       = {byte_i, hold_q};
  assign pending_o    = pend_q;

  // R8: second byte always closes the pair
  a_r8_pair_closes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && byte_valid_i && !clear_i) |=> !pend_q);
  // R10: clear drops held byte
  a_r10_clear_byte: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> !pend_q);
endmodule

// File: rtl/ccd_word_decode.sv
module ccd_word_decode
  import ccd_pkg::*;
#(
  parameter int NUM_REGS = 24,
  parameter int M4_REGS  = 11
) (
  input  logic              mode5_i,
  input  logic              pending_i,
  input  logic              from_byte_i,
  input  logic [WORD_W-1:0] word_i,
  input  cmd_state_t        cur_i,
  output cmd_state_t        nxt_o,
  output logic              reg_hit_o,
  output logic [IDX_W-1:0]  reg_idx_o,
  output logic [BYTE_W-1:0] reg_data_o,
  output logic              set_pending_o,
  output logic              clr_pending_o,
  output logic              clr_fetch_o
);
  localparam int LIMIT_W = IDX_W + 2;

  logic [LIMIT_W-1:0] limit;
  logic               is_reg;

  assign limit      = mode5_i ? LIMIT_W'(NUM_REGS) : LIMIT_W'(M4_REGS);
  assign is_reg     = (word_i[WORD_W-1 -: 2] == KIND_REG);
  assign reg_idx_o  = word_i[IDX_W+BYTE_W-1:BYTE_W];
  assign reg_data_o = word_i[BYTE_W-1:0];

  always_comb begin
    nxt_o         = cur_i;
    reg_hit_o     = 1'b0;
    set_pending_o = 1'b0;
    clr_pending_o = 1'b0;
    clr_fetch_o   = 1'b0;
    if (pending_i) begin
      // second word: only the top address bits are taken
      nxt_o.addr[WORD_W-1:LO_ADDR_W] = word_i[HI_ADDR_W-1:0];
      clr_pending_o = 1'b1;
    end else begin
      nxt_o.addr[LO_ADDR_W-1:0] = word_i[LO_ADDR_W-1:0];
      nxt_o.code = {mode5_i ? cur_i.code[CODE_W-1:2] : '0, word_i[WORD_W-1 -: 2]};
      if (is_reg) begin
        reg_hit_o = ({2'b00, reg_idx_o} < limit);
      end else if (mode5_i) begin
        set_pending_o = 1'b1;
      end else begin
        clr_fetch_o = 1'b1;
      end
    end
    if (from_byte_i && nxt_o.code == CODE_VRAM_RD16) begin
      nxt_o.code = CODE_VRAM_RD8;
    end
  end
endmodule

// File: rtl/ctrl_cmd_decoder.sv
module ctrl_cmd_decoder
  import ccd_pkg::*;
#(
  parameter int NUM_REGS = 24,
  parameter int M4_REGS  = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode5_i,
  input  logic              wr16_valid_i,
  input  logic [WORD_W-1:0] wr16_data_i,
  input  logic              wr8_valid_i,
  input  logic [BYTE_W-1:0] wr8_data_i,
  input  logic              rd_i,
  output logic              reg_we_o,
  output logic [IDX_W-1:0]  reg_idx_o,
  output logic [BYTE_W-1:0] reg_data_o,
  output logic [WORD_W-1:0] addr_o,
  output logic [CODE_W-1:0] code_o,
  output logic              cmd_pending_o,
  output logic              byte_pending_o,
  output logic              clr_fetch_o
);
  cmd_state_t        st_q, st_nxt;
  logic              pend_q, we_q, clrf_q;
  logic [IDX_W-1:0]  idx_q;
  logic [BYTE_W-1:0] data_q;

  logic              join_valid;
  logic [WORD_W-1:0] join_word;
  logic              byte_accept;
  logic              word_go;
  logic [WORD_W-1:0] word_sel;
  logic              hit, set_p, clr_p, clr_f;
  logic [IDX_W-1:0]  dec_idx;
  logic [BYTE_W-1:0] dec_data;

  assign byte_accept = wr8_valid_i & ~wr16_valid_i & ~rd_i;

  ccd_byte_joiner u_join (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .byte_valid_i (byte_accept),
    .byte_i       (wr8_data_i),
    .clear_i      (rd_i),
    .word_valid_o (join_valid),
    .word_o       (join_word),
    .pending_o    (byte_pending_o)
  );

  assign word_go  = ~rd_i & (wr16_valid_i | join_valid);
  assign word_sel = wr16_valid_i ? wr16_data_i : join_word;

  ccd_word_decode #(.NUM_REGS(NUM_REGS), .M4_REGS(M4_REGS)) u_dec (
    .mode5_i       (mode5_i),
    .pending_i     (pend_q),
    .from_byte_i   (~wr16_valid_i),
    .word_i        (word_sel),
    .cur_i         (st_q),
    .nxt_o         (st_nxt),
    .reg_hit_o     (hit),
    .reg_idx_o     (dec_idx),
    .reg_data_o    (dec_data),
    .set_pending_o (set_p),
    .clr_pending_o (clr_p),
    .clr_fetch_o   (clr_f)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= '0;
      pend_q <= 1'b0;
      we_q   <= 1'b0;
      clrf_q <= 1'b0;
      idx_q  <= '0;
      data_q <= '0;
    end else begin
      we_q   <= 1'b0;
      clrf_q <= 1'b0;
      if (rd_i) begin
        pend_q <= 1'b0;
      end else if (word_go) begin
        st_q   <= st_nxt;
        we_q   <= hit;
        clrf_q <= clr_f;
        if (hit) begin
          idx_q  <= dec_idx;
          data_q <= dec_data;
        end
        if (set_p)      pend_q <= 1'b1;
        else if (clr_p) pend_q <= 1'b0;
      end
    end
  end

  assign reg_we_o      = we_q;
  assign reg_idx_o     = idx_q;
  assign reg_data_o    = data_q;
  assign addr_o        = st_q.addr;
  assign code_o        = st_q.code;
  assign cmd_pending_o = pend_q;
  assign clr_fetch_o   = clrf_q;

  // R5: strobed index always within the limit of the protocol in use
  a_r5_idx_limit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |-> (int'(reg_idx_o) < ($past(mode5_i) ? NUM_REGS : M4_REGS)));
  // R10: read clears the sequence state
  a_r10_read_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i |=> (!cmd_pending_o && !byte_pending_o));
  // R7: single-word protocol never leaves a command pending
  a_r7_m4_no_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode5_i && !cmd_pending_o && wr16_valid_i && !rd_i) |=> !cmd_pending_o);
  // R3: 16-bit word in single-word protocol clears upper code bits
  a_r3_m4_code_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode5_i && !cmd_pending_o && wr16_valid_i && !rd_i) |=> (code_o[5:2] == 4'b0000));
  // R4: at most one of the two pulses per cycle
  a_r4_one_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({reg_we_o, clr_fetch_o}));
  // R6: second word keeps the low address bits
  a_r6_second_keeps_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_pending_o && wr16_valid_i && !rd_i) |=>
      ($stable(addr_o[13:0]) && $stable(code_o) && !cmd_pending_o));
endmodule

// File: tb/ctrl_cmd_decoder_tb_top.sv
`timescale 1ns/100ps
module ctrl_cmd_decoder_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode5 = 1'b0, wr16_v = 1'b0, wr8_v = 1'b0, rd = 1'b0;
  logic [15:0] wr16_d = '0;
  logic [7:0]  wr8_d = '0;
  logic        reg_we, cmd_pend, byte_pend, clrf;
  logic [4:0]  reg_idx;
  logic [7:0]  reg_data;
  logic [15:0] addr;
  logic [5:0]  code;

  always #2.5 clk = ~clk;

  ctrl_cmd_decoder dut_i (
    .clk_i(clk), .rst_ni(rst_n), .mode5_i(mode5),
    .wr16_valid_i(wr16_v), .wr16_data_i(wr16_d),
    .wr8_valid_i(wr8_v), .wr8_data_i(wr8_d), .rd_i(rd),
    .reg_we_o(reg_we), .reg_idx_o(reg_idx), .reg_data_o(reg_data),
    .addr_o(addr), .code_o(code), .cmd_pending_o(cmd_pend),
    .byte_pending_o(byte_pend), .clr_fetch_o(clrf)
  );

  typedef struct {
    string       tag;
    logic [15:0] addr;
    logic [5:0]  code;
    logic        pend, bpend, we, clrf;
    logic [4:0]  idx;
    logic [7:0]  data;
  } exp_t;

  exp_t q[$];
  int   n_vec = 0, n_bad = 0;
  bit   done = 1'b0;

  // reference state
  logic [15:0] m_addr = '0;
  logic [5:0]  m_code = '0;
  logic        m_pend = 1'b0, m_bpend = 1'b0;
  logic [7:0]  m_hold = '0;

  task automatic decode(input logic m5, input logic [15:0] w, input bit fb, inout exp_t e);
    if (m_pend) begin
      m_addr[15:14] = w[1:0];
      m_pend = 1'b0;
    end else begin
      m_addr[13:0] = w[13:0];
      m_code = {m5 ? m_code[5:2] : 4'b0000, w[15:14]};
      if (w[15:14] == 2'b10) begin
        if (int'(w[12:8]) < (m5 ? 24 : 11)) begin
          e.we = 1'b1; e.idx = w[12:8]; e.data = w[7:0];
        end
      end else if (m5) m_pend = 1'b1;
      else e.clrf = 1'b1;
    end
    if (fb && m_code == 6'b000000) m_code = 6'b001100;
  endtask

  task automatic step(input string tag, input logic m5, input logic v16, input logic [15:0] d16,
                      input logic v8, input logic [7:0] d8, input logic r);
    exp_t e;
    e.tag = tag; e.we = 1'b0; e.clrf = 1'b0; e.idx = '0; e.data = '0;
    mode5 = m5; wr16_v = v16; wr16_d = d16; wr8_v = v8; wr8_d = d8; rd = r;
    if (r) begin
      m_pend = 1'b0; m_bpend = 1'b0;
    end else if (v16) begin
      decode(m5, d16, 1'b0, e);
    end else if (v8) begin
      if (m_bpend) begin
        m_bpend = 1'b0;
        decode(m5, {d8, m_hold}, 1'b1, e);
      end else begin
        m_hold = d8; m_bpend = 1'b1;
      end
    end
    e.addr = m_addr; e.code = m_code; e.pend = m_pend; e.bpend = m_bpend;
    q.push_back(e);
    @(negedge clk);
  endtask

  // monitor: compare just after the edge that produced the result
  always @(posedge clk) begin
    #2;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      n_vec++;
      if (addr !== e.addr || code !== e.code || cmd_pend !== e.pend ||
          byte_pend !== e.bpend || reg_we !== e.we || clrf !== e.clrf ||
          (e.we && (reg_idx !== e.idx || reg_data !== e.data))) begin
        n_bad++;
        $display("FAIL %s: got addr=%h code=%h pend=%b bpend=%b we=%b idx=%h data=%h clrf=%b exp addr=%h code=%h pend=%b bpend=%b we=%b idx=%h data=%h clrf=%b",
                 e.tag, addr, code, cmd_pend, byte_pend, reg_we, reg_idx, reg_data, clrf,
                 e.addr, e.code, e.pend, e.bpend, e.we, e.idx, e.data, e.clrf);
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    n_vec++;
    if (addr !== 16'h0 || code !== 6'h0 || cmd_pend !== 1'b0 || byte_pend !== 1'b0 ||
        reg_we !== 1'b0 || clrf !== 1'b0) begin
      n_bad++;
      $display("FAIL R1 in reset: got addr=%h code=%h pend=%b bpend=%b exp all zero",
               addr, code, cmd_pend, byte_pend);
    end
    rst_n = 1'b1;
    @(negedge clk);
    step("R1 idle after reset",        0, 0, 16'h0000, 0, 8'h00, 0);
    step("R2 R3 R7 m4 address word",   0, 1, 16'h4123, 0, 8'h00, 0);
    step("R4 m4 reg 10",               0, 1, 16'h8A55, 0, 8'h00, 0);
    step("R5 m4 reg 11 rejected",      0, 1, 16'h8B01, 0, 8'h00, 0);
    step("R4 m5 reg 23",               1, 1, 16'h9701, 0, 8'h00, 0);
    step("R5 m5 reg 24 rejected",      1, 1, 16'h9801, 0, 8'h00, 0);
    step("R6 m5 first word",           1, 1, 16'h7ABC, 0, 8'h00, 0);
    step("R6 m5 second word",          1, 1, 16'h0003, 0, 8'h00, 0);
    step("R2 top address kept",        1, 1, 16'hC010, 0, 8'h00, 0);
    step("R10 read with write ignored",1, 1, 16'h0002, 0, 8'h00, 1);
    step("R8 m4 low byte",             0, 0, 16'h0000, 1, 8'h34, 0);
    step("R8 R9 m4 high byte",         0, 0, 16'h0000, 1, 8'h12, 0);
    step("R3 m5 keeps upper code",     1, 1, 16'h4000, 0, 8'h00, 0);
    step("R6 second after keep",       1, 1, 16'h0001, 0, 8'h00, 0);
    step("R3 m4 clears upper code",    0, 1, 16'h4000, 0, 8'h00, 0);
    step("R8 low byte no convert",     0, 0, 16'h0000, 1, 8'h00, 0);
    step("R9 code 01 not converted",   0, 0, 16'h0000, 1, 8'h40, 0);
    step("R8 low byte reg",            0, 0, 16'h0000, 1, 8'h07, 0);
    step("R4 R8 byte reg write",       0, 0, 16'h0000, 1, 8'h85, 0);
    step("R11 both writes",            0, 1, 16'h0155, 1, 8'hEE, 0);
    step("R8 low byte before read",    1, 0, 16'h0000, 1, 8'h00, 0);
    step("R10 read clears byte",       1, 0, 16'h0000, 1, 8'h99, 1);
    step("R9 m4 byte read code",       0, 0, 16'h0000, 1, 8'h00, 0);
    step("R9 m4 byte read code hi",    0, 0, 16'h0000, 1, 8'h20, 0);
    step("R6 m5 byte first word",      1, 0, 16'h0000, 1, 8'h00, 0);
    step("R6 R9 m5 byte first word hi",1, 0, 16'h0000, 1, 8'h00, 0);
    step("R10 read clears cmd",        1, 0, 16'h0000, 0, 8'h00, 1);
    step("R7 pulse gone",              0, 0, 16'h0000, 0, 8'h00, 0);
    step("R1 idle tail",               0, 0, 16'h0000, 0, 8'h00, 0);
    @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got hung run exp completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule